// File: doc/BRIEF.md
# ATA PIO Mode Capability Selector

This block listens to the 256-word IDENTIFY DEVICE response of an ATA drive. The response arrives as 16-bit words, each tagged with an 8-bit word index. The block keeps only the four words that bear on PIO capability: 51, 53, 64 and 68. Once the final word has been taken in, it chooses the fastest PIO timing mode that the drive can safely run and decides whether IORDY flow control should be enabled.

The drive's advertised advanced mode is not taken at face value. The drive's reported minimum IORDY cycle time (word 68) can lower that mode one step at a time at 120, 180 and 240 ns. If the advanced fields are invalid or unusable, the coarse PIO field in word 51 decides instead.

A controller pulses `start_i`, streams the words in, and waits for `done_o`. It then programs its timing from `mode_o` and `iordy_en_o`. These outputs keep their value until the next decision.

Top module: `pio_mode_sel`

## Requirements
- R1: During and right after reset, `done_o` is 0, `mode_o` is 0 and `iordy_en_o` is 0.
- R2: Words are accepted only while armed. A `start_i` pulse arms the block. Accepting the word with index 255 disarms it. Words that arrive while disarmed have no effect and produce no `done_o`.
- R3: `start_i` clears all captured words to zero. A word presented in the same cycle as `start_i` is dropped. A stream cut short by a new `start_i` produces no `done_o`, and none of its words affect the next decision.
- R4: If bit 1 of word 53 is 0, words 64 and 68 are ignored and the decision follows word 51.
- R5: If word 68 is zero, the decision follows word 51.
- R6: With the advanced fields usable and bit 1 of word 64 set (PIO4 advertised, whatever bit 0 holds), the cycle time t from word 68, read as unsigned, selects the mode:
  - t <= 120 gives 4
  - t <= 180 gives 3
  - t <= 240 gives 2
  - otherwise 0
- R7: With the advanced fields usable, only bit 0 of word 64 set (PIO3), the cycle time selects the mode:
  - t <= 180 gives 3
  - t <= 240 gives 2
  - otherwise 0
- R8: On the word 51 path, bits 15:8 of 02h or more give mode 2. Values 00h and 01h give mode 0. This also applies when word 64 advertises neither advanced mode.
- R9: `iordy_en_o` is 1 exactly when the chosen mode is 3 or 4.
- R10: `mode_o` uses the codes 0 (compatible/PIO0), 2, 3 and 4. It and `iordy_en_o` change only in the cycle when `done_o` is 1, and otherwise hold their value.
- R11: `done_o` is high for exactly one cycle. That cycle is the one right after the clock edge that accepts word 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the captured words and arms a new capture |
| word_valid_i | input | 1 | `word_i` and `index_i` are valid |
| word_i | input | 16 | IDENTIFY DEVICE data word |
| index_i | input | 8 | Word index, 0 to 255 |
| done_o | output | 1 | One-cycle pulse when a new decision is available |
| mode_o | output | 3 | Chosen PIO mode: 0, 2, 3 or 4 |
| iordy_en_o | output | 1 | Use IORDY flow control |

## Verification
The assertions check on every cycle that `done_o` lasts a single cycle and follows an accepted word 255. They also check that the mode code is always legal, that IORDY is enabled only for modes 3 and 4, and that the outputs hold between decisions. Several behaviours can only be shown by the bench's scenarios:
- where each downgrade threshold falls, on both sides of 120, 180 and 240 ns
- that the PIO4 bit takes precedence over the PIO3 bit
- that the validity bit and a zero cycle time send the decision to word 51
- that an aborted stream or a word sent while disarmed leaves no trace

// File: rtl/pio_sel_pkg.sv
package pio_sel_pkg;
  localparam int unsigned ID_DW = 16;

  typedef enum logic [2:0] {
    PIO_COMPAT = 3'd0,
    PIO_2      = 3'd2,
    PIO_3      = 3'd3,
    PIO_4      = 3'd4
  } pio_mode_e;

  typedef struct packed {
    logic [ID_DW-1:0] w51;
    logic [ID_DW-1:0] w53;
    logic [ID_DW-1:0] w64;
    logic [ID_DW-1:0] w68;
  } id_words_t;

  typedef struct packed {
    pio_mode_e mode;
    logic      iordy;
  } pio_result_t;
endpackage

// File: rtl/pio_word_capture.sv
module pio_word_capture
  import pio_sel_pkg::*;
#(
  parameter int unsigned IW       = 8,
  parameter int unsigned LAST_IDX = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [ID_DW-1:0] word_i,
  input  logic [IW-1:0]    index_i,
  output id_words_t        words_o,
  output logic             last_o
);
  localparam int unsigned NTRK = 4;
  localparam int unsigned TRACK_IDX [NTRK] = '{51, 53, 64, 68};

  logic armed_q;
  logic accept;
  logic [ID_DW-1:0] word_q [NTRK];

  assign accept = armed_q && valid_i && !start_i;
  assign last_o = accept && (index_i == IW'(LAST_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;
    else if (last_o)  armed_q <= 1'b0;
  end

  for (genvar g = 0; g < NTRK; g++) begin : g_trk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      word_q[g] <= '0;
      else if (start_i)                                 word_q[g] <= '0;
      else if (accept && index_i == IW'(TRACK_IDX[g])) word_q[g] <= word_i;
    end
  end

  assign words_o.w51 = word_q[0];
  assign words_o.w53 = word_q[1];
  assign words_o.w64 = word_q[2];
  assign words_o.w68 = word_q[3];
endmodule

// File: rtl/pio_cycle_grade.sv
module pio_cycle_grade
  import pio_sel_pkg::*;
#(
  parameter int unsigned T_FAST = 120,
  parameter int unsigned T_MID  = 180,
  parameter int unsigned T_SLOW = 240
) (
  input  logic [ID_DW-1:0] cyc_i,
  output logic             le_fast_o,
  output logic             le_mid_o,
  output logic             le_slow_o
);
  assign le_fast_o = cyc_i <= ID_DW'(T_FAST);
  assign le_mid_o  = cyc_i <= ID_DW'(T_MID);
  assign le_slow_o = cyc_i <= ID_DW'(T_SLOW);
endmodule

// File: rtl/pio_mode_decide.sv
module pio_mode_decide
  import pio_sel_pkg::*;
#(
  parameter int unsigned VALID_BIT = 1,
  parameter int unsigned P4_BIT    = 1,
  parameter int unsigned P3_BIT    = 0
) (
  input  id_words_t   words_i,
  input  logic        le_fast_i,
  input  logic        le_mid_i,
  input  logic        le_slow_i,
  output pio_result_t res_o
);
  logic adv_ok;
  logic [7:0] base_mode;

  assign adv_ok    = words_i.w53[VALID_BIT] && (words_i.w68 != '0);
  assign base_mode = words_i.w51[15:8];

  always_comb begin
    res_o = '{mode: PIO_COMPAT, iordy: 1'b0};
    if (adv_ok && words_i.w64[P4_BIT]) begin
      if (le_fast_i)      res_o = '{mode: PIO_4, iordy: 1'b1};
      else if (le_mid_i)  res_o = '{mode: PIO_3, iordy: 1'b1};
      else if (le_slow_i) res_o.mode = PIO_2;
    end else if (adv_ok && words_i.w64[P3_BIT]) begin
      if (le_mid_i)       res_o = '{mode: PIO_3, iordy: 1'b1};
      else if (le_slow_i) res_o.mode = PIO_2;
    end else if (base_mode >= 8'd2) begin
      // word 51 PIO2 implies a 240 ns cycle; no time check
      res_o.mode = PIO_2;
    end
  end
endmodule

// File: rtl/pio_mode_sel.sv
module pio_mode_sel
  import pio_sel_pkg::*;
#(
  parameter int unsigned IW       = 8,
  parameter int unsigned LAST_IDX = 255,
  parameter int unsigned T_FAST   = 120,
  parameter int unsigned T_MID    = 180,
  parameter int unsigned T_SLOW   = 240
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        word_valid_i,
  input  logic [15:0] word_i,
  input  logic [7:0]  index_i,
  output logic        done_o,
  output logic [2:0]  mode_o,
  output logic        iordy_en_o
);
  id_words_t   words;
  logic        last;
  logic        le_fast, le_mid, le_slow;
  pio_result_t res_d, res_q;
  logic        done_q;

  pio_word_capture #(.IW(IW), .LAST_IDX(LAST_IDX)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (word_valid_i),
    .word_i  (word_i),
    .index_i (index_i),
    .words_o (words),
    .last_o  (last)
  );

  pio_cycle_grade #(.T_FAST(T_FAST), .T_MID(T_MID), .T_SLOW(T_SLOW)) i_grade (
    .cyc_i     (words.w68),
    .le_fast_o (le_fast),
    .le_mid_o  (le_mid),
    .le_slow_o (le_slow)
  );

  pio_mode_decide i_decide (
    .words_i   (words),
    .le_fast_i (le_fast),
    .le_mid_i  (le_mid),
    .le_slow_i (le_slow),
    .res_o     (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '{mode: PIO_COMPAT, iordy: 1'b0};
    end else begin
      done_q <= last;
      if (last) res_q <= res_d;
    end
  end

  assign done_o     = done_q;
  assign mode_o     = res_q.mode;
  assign iordy_en_o = res_q.iordy;
endmodule

// File: rtl/pio_mode_sel_chk.sv
module pio_mode_sel_chk #(
  parameter int unsigned IW       = 8,
  parameter int unsigned LAST_IDX = 255
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          word_valid_i,
  input logic [IW-1:0] index_i,
  input logic          done_o,
  input logic [2:0]    mode_o,
  input logic          iordy_en_o
);
  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(word_valid_i) && $past(index_i) == IW'(LAST_IDX)));

  // R10
  mode_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o inside {3'd0, 3'd2, 3'd3, 3'd4});

  // R9
  iordy_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iordy_en_o == (mode_o == 3'd3 || mode_o == 3'd4));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(mode_o) && $stable(iordy_en_o)));
endmodule

bind pio_mode_sel pio_mode_sel_chk #(.IW(IW), .LAST_IDX(LAST_IDX)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .index_i      (index_i),
  .done_o       (done_o),
  .mode_o       (mode_o),
  .iordy_en_o   (iordy_en_o)
);

// File: tb/test_pio_mode_sel.sv
`timescale 1ns/1ps
module test_pio_mode_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wv = 1'b0;
  logic [15:0] wd = '0;
  logic [7:0]  idx = '0;
  logic        done;
  logic [2:0]  mode;
  logic        iordy;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pio_mode_sel i_pio_mode_sel (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_valid_i(wv),
    .word_i(wd), .index_i(idx), .done_o(done), .mode_o(mode), .iordy_en_o(iordy)
  );

  // behavioural reference
  logic [15:0] m_w [256];
  bit m_armed;
  bit e_done;
  int e_mode;
  bit e_iordy;

  function automatic void ref_decide(input logic [15:0] a51, a53, a64, a68,
                                     output int m, output bit io);
    bit ok = a53[1] && (a68 != 0);
    if (ok && a64[1])      m = (a68 <= 120) ? 4 : (a68 <= 180) ? 3 : (a68 <= 240) ? 2 : 0;
    else if (ok && a64[0]) m = (a68 <= 180) ? 3 : (a68 <= 240) ? 2 : 0;
    else                   m = (a51[15:8] >= 2) ? 2 : 0;
    io = (m >= 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; e_done = 0; e_mode = 0; e_iordy = 0;
      foreach (m_w[i]) m_w[i] = '0;
    end else begin
      e_done = 0;
      if (start) begin
        m_armed = 1;
        foreach (m_w[i]) m_w[i] = '0;
      end else if (m_armed && wv) begin
        m_w[idx] = wd;
        if (idx == 8'd255) begin
          m_armed = 0;
          e_done = 1;
          ref_decide(m_w[51], m_w[53], m_w[64], m_w[68], e_mode, e_iordy);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(done == e_done, "R11 done", done, e_done);
    chk(mode == 3'(e_mode), "R10 mode", mode, e_mode);
    chk(iordy == e_iordy, "R9 iordy", iordy, e_iordy);
  end

  task automatic pulse_start();
    @(negedge clk); start = 1; wv = 0;
    @(negedge clk); start = 0;
  endtask

  task automatic send(input logic [15:0] v51, v53, v64, v68, input bit skip, input int upto);
    for (int i = 0; i <= upto; i++) begin
      @(negedge clk);
      idx = 8'(i);
      case (i)
        51: wd = v51;
        53: wd = v53;
        64: wd = v64;
        68: wd = v68;
        default: wd = 16'hA5A5 ^ 16'(i * 7);
      endcase
      wv = !(skip && (i == 51 || i == 53 || i == 64 || i == 68));
    end
    @(negedge clk); wv = 0;
  endtask

  // full stream then check result at the done cycle
  task automatic run(input logic [15:0] v51, v53, v64, v68,
                     input int xm, input bit xi, input string tag);
    pulse_start();
    send(v51, v53, v64, v68, 0, 255);
    chk(done == 1, {tag, " done"}, done, 1);
    chk(mode == 3'(xm), {tag, " mode"}, mode, xm);
    chk(iordy == xi, {tag, " iordy"}, iordy, xi);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20;
    // R1
    chk(done == 0 && mode == 0 && iordy == 0, "R1 reset", {done, mode, iordy}, 0);
    #11 rst_n = 1;
    @(negedge clk);
    chk(done == 0 && mode == 0 && iordy == 0, "R1 after reset", {done, mode, iordy}, 0);

    // R6 thresholds
    run(16'h0200, 16'h0002, 16'h0002, 16'd120, 4, 1, "R6 t120");
    run(16'h0200, 16'h0002, 16'h0002, 16'd121, 3, 1, "R6 t121");
    run(16'h0200, 16'h0002, 16'h0002, 16'd180, 3, 1, "R6 t180");
    run(16'h0200, 16'h0002, 16'h0002, 16'd181, 2, 0, "R6 t181");
    run(16'h0200, 16'h0002, 16'h0002, 16'd240, 2, 0, "R6 t240");
    run(16'h0200, 16'h0002, 16'h0002, 16'd241, 0, 0, "R6 t241");
    run(16'h0200, 16'h0002, 16'h0002, 16'hFFFF, 0, 0, "R6 unsigned max");
    run(16'h0000, 16'h0002, 16'h0003, 16'd100, 4, 1, "R6 precedence");
    // R7
    run(16'h0200, 16'h0002, 16'h0001, 16'd100, 3, 1, "R7 t100");
    run(16'h0200, 16'h0002, 16'h0001, 16'd181, 2, 0, "R7 t181");
    run(16'h0200, 16'h0002, 16'h0001, 16'd241, 0, 0, "R7 t241");
    // R4
    run(16'h0200, 16'hFFFD, 16'h0003, 16'd100, 2, 0, "R4 invalid");
    run(16'h0100, 16'h0000, 16'h0002, 16'd100, 0, 0, "R4 invalid base1");
    // R5
    run(16'h0100, 16'h0002, 16'h0002, 16'd0, 0, 0, "R5 zero time");
    run(16'h0300, 16'h0002, 16'h0003, 16'd0, 2, 0, "R5 zero time base3");
    // R8
    run(16'h05FF, 16'h0000, 16'h0000, 16'd0, 2, 0, "R8 above 2");
    run(16'h01FF, 16'h0000, 16'h0000, 16'd0, 0, 0, "R8 base1");
    run(16'h0000, 16'h0000, 16'h0000, 16'd0, 0, 0, "R8 base0");
    run(16'h0200, 16'h0002, 16'h00FC, 16'd100, 2, 0, "R8 no adv bits");

    // R10 hold over idle cycles
    run(16'h0000, 16'h0002, 16'h0002, 16'd90, 4, 1, "R10 set");
    repeat (5) @(negedge clk);
    chk(mode == 3'd4 && iordy == 1 && done == 0, "R10 hold", mode, 4);

    // R2 words while disarmed
    send(16'h0000, 16'h0000, 16'h0000, 16'd0, 0, 255);
    chk(done == 0, "R2 disarmed done", done, 0);
    chk(mode == 3'd4, "R2 disarmed mode", mode, 4);

    // R3 aborted stream then restart without tracked words
    pulse_start();
    send(16'h0200, 16'h0002, 16'h0002, 16'd100, 0, 120);
    pulse_start();
    send(16'h0200, 16'h0002, 16'h0002, 16'd100, 1, 255);
    chk(done == 1, "R3 restart done", done, 1);
    chk(mode == 3'd0, "R3 cleared words", mode, 0);

    // R3 word alongside start dropped
    pulse_start();
    send(16'h0200, 16'h0002, 16'h0002, 16'd100, 0, 254);
    @(negedge clk); start = 1; wv = 1; idx = 8'd255; wd = '0;
    @(negedge clk); start = 0; wv = 0;
    chk(done == 0, "R3 start wins", done, 0);
    send(16'h0100, 16'h0000, 16'h0000, 16'd0, 1, 255);
    chk(done == 1 && mode == 3'd0, "R3 rearmed", mode, 0);

    // R11 single pulse
    @(negedge clk);
    chk(done == 0, "R11 pulse end", done, 0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule